// File: doc/BRIEF.md
# I2C Master Transmitter with Transmit Queue

This block is a bus master that only writes. Software loads bytes into a 16-entry transmit queue and shapes the transfer by writing a small control register. The first byte queued for a transfer is the target address and the data bytes follow it. The queue may be filled before the transfer is requested. The block drives the clock and data lines through active-low output enables, so the pads only pull low or release. It reads the data line back to sample the acknowledge bit.

The transfer is framed entirely by the control bits. The block generates a START when it is enabled and both the master bit and the transmit bit are set. It then sends queued bytes MSB first. When the queue runs dry, the block parks the bus with SCL held low and raises an interrupt until more bytes arrive. Setting the restart bit while the bus is parked produces a repeated START, and the next queued byte then goes out as a fresh address. Clearing the master bit makes the block finish with a STOP once the byte it is sending leaves the queue empty. A NACK from the target ends the transfer at once.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset both line enables are 0 (lines released), the interrupt is 0, and status reads busy 0, empty 1, full 0, nack 0, overflow 0, restart-pending 0. Status bits: [0] busy, [1] queue empty, [2] queue full, [3] nack, [4] overflow, [5] restart pending.
- R2: Control bits are [0] enable, [1] queue flush, [2] master, [3] transmit, [4] restart. When the block is idle with enable, master and transmit all 1, it issues a START (SDA falls while SCL is high). It then sends the queued bytes in write order, MSB first, and the first byte is the address.
- R3: Outside START, repeated START and STOP, SDA changes only while SCL is low.
- R4: When the queue is empty after a byte and the master bit is still set, SCL is held low, the interrupt is 1, and no bits are sent. Transmission resumes after a byte is written.
- R5: A restart bit set while the bus is parked produces a repeated START, after which the next queued byte is sent. The restart-pending status returns to 0 once the repeated START has been issued.
- R6: With the master bit cleared, a STOP (SDA rises while SCL is high) follows the first byte after which the queue is empty, and busy then returns to 0.
- R7: After each byte, ackValid pulses with ackNack equal to the sampled ninth bit (1 = NACK). A NACK sets the sticky nack status, and the block then issues a STOP, empties the queue and clears the master bit, so no new transfer starts. The next START clears the nack status.
- R8: The queue holds 16 bytes and full reads 1 at 16. A write while full is dropped and sets the sticky overflow status.
- R9: A control write with the flush bit set empties the queue and clears overflow.
- R10: With transmit or enable at 0, setting the master bit starts nothing: busy stays 0 and SCL stays released.
- R11: Each SCL period within a byte lasts 4 × QUARTER_CYCLES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 5 | Control value (enable, flush, master, transmit, restart) |
| fifoWe | input | 1 | Transmit queue write strobe |
| fifoWdata | input | 8 | Byte to queue |
| sdaIn | input | 1 | Data line as seen at the pad |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| status | output | 6 | Status word, bit layout in R1 |
| txEmptyIrq | output | 1 | Bus parked with empty queue |
| ackValid | output | 1 | One-cycle pulse after each acknowledge bit |
| ackNack | output | 1 | Sampled acknowledge bit, 1 = NACK |

## Verification
The case that is hardest to reach from the ports is the bus parked in the middle of a transfer. Reaching it needs a queue that has drained exactly, and a control write has to land while the bus is held, either a restart or a cleared master bit. The bench watches the interrupt and writes only after it rises. A bus-level target model decodes the line pins into START, repeated START, STOP and byte events and can NACK a chosen byte. All 256 data values are pushed through a single long transfer, and each decoded byte is compared with the value pushed.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;
  localparam int CTRL_W   = 5;
  localparam int CB_EN    = 0;
  localparam int CB_FLUSH = 1;
  localparam int CB_MSMS  = 2;
  localparam int CB_TX    = 3;
  localparam int CB_RSTA  = 4;
  localparam int STAT_W   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BIT, ST_RSTART, ST_STOP
  } ctlState_t;

  typedef struct packed {
    logic pop;
    logic shift;
    logic flush;
    logic sampleAck;
    logic clrNack;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_tx_dpath.sv
module i2c_tx_dpath
  import i2c_tx_pkg::*;
#(
  parameter int FIFO_DEPTH     = 16,
  parameter int QUARTER_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic       fifoWe,
  input  logic [7:0] fifoWdata,
  input  logic       sdaIn,
  output logic       tick,
  output logic       fifoEmpty,
  output logic       fifoFull,
  output logic       txBit,
  output logic       lastNack,
  output logic       nackFlag,
  output logic       overflow,
  output logic       ackValid,
  output logic       ackNack
);
  // FIFO_DEPTH must be a power of two so the pointers wrap on their own.
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(FIFO_DEPTH);
  localparam logic [CW-1:0] DIV_LAST = CW'(QUARTER_CYCLES - 1);

  logic [CW-1:0] divCnt;
  logic [7:0]    mem [FIFO_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   cnt;
  logic [7:0]    shiftQ;
  logic [1:0]    sdaSync;
  logic          pushOk, popOk;

  assign tick      = (divCnt == DIV_LAST);
  assign fifoEmpty = (cnt == '0);
  assign fifoFull  = (cnt == FULL_CNT);
  assign pushOk    = fifoWe && !fifoFull;
  assign popOk     = stb.pop && !fifoEmpty;
  assign txBit     = shiftQ[7];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;

  always_ff @(posedge clk)
    if (pushOk && !stb.flush) mem[wrPtr] <= fifoWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; cnt <= '0; overflow <= 1'b0; shiftQ <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0; rdPtr <= '0; cnt <= '0; overflow <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popOk) begin
        rdPtr  <= rdPtr + 1'b1;
        shiftQ <= mem[rdPtr];
      end else if (stb.shift) begin
        shiftQ <= {shiftQ[6:0], 1'b0};
      end
      if (pushOk && !popOk)      cnt <= cnt + 1'b1;
      else if (popOk && !pushOk) cnt <= cnt - 1'b1;
      if (fifoWe && fifoFull) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaSync <= 2'b11; lastNack <= 1'b0; nackFlag <= 1'b0;
      ackValid <= 1'b0; ackNack <= 1'b0;
    end else begin
      sdaSync  <= {sdaSync[0], sdaIn};
      ackValid <= stb.sampleAck;
      if (stb.sampleAck) begin
        lastNack <= sdaSync[1];
        ackNack  <= sdaSync[1];
        if (sdaSync[1]) nackFlag <= 1'b1;
      end else if (stb.clrNack) begin
        nackFlag <= 1'b0;
      end
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWe && fifoFull && !stb.pop && !stb.flush) |=> (cnt == $past(cnt)) && overflow);

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> fifoEmpty && !overflow);
endmodule

// File: rtl/i2c_tx_ctrl.sv
module i2c_tx_ctrl
  import i2c_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              tick,
  input  logic              fifoEmpty,
  input  logic              txBit,
  input  logic              lastNack,
  output dpStrobe_t         stb,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busy,
  output logic              rstaPending,
  output logic              txEmptyIrq
);
  ctlState_t stateQ, stateD;
  logic [1:0] qQ, qD;
  logic [3:0] bitQ, bitD;
  logic enQ, msmsQ, txQ, rstaQ;
  logic msmsClr, rstaClr, sclLow, sdaLow;

  assign busy        = (stateQ != ST_IDLE);
  assign rstaPending = rstaQ;
  assign txEmptyIrq  = (stateQ == ST_HOLD) && fifoEmpty;

  always_comb begin
    stb = '0; stateD = stateQ; qD = qQ; bitD = bitQ; msmsClr = 1'b0; rstaClr = 1'b0;
    stb.flush = ctrlWe && ctrlWdata[CB_FLUSH];
    if (!enQ) begin
      stateD = ST_IDLE; qD = '0;
    end else if (tick) begin
      case (stateQ)
        ST_IDLE: if (msmsQ && txQ) begin
          stateD = ST_START; qD = '0; stb.clrNack = 1'b1;
        end
        ST_START, ST_RSTART, ST_STOP: begin
          qD = qQ + 2'd1;
          if (qQ == 2'd3) begin
            stateD  = (stateQ == ST_STOP) ? ST_IDLE : ST_HOLD;
            rstaClr = (stateQ == ST_RSTART);
          end
        end
        ST_HOLD: if (rstaQ) begin
          stateD = ST_RSTART; qD = '0;
        end else if (!fifoEmpty) begin
          stb.pop = 1'b1; stateD = ST_BIT; qD = '0; bitD = '0;
        end
        ST_BIT: begin
          qD = qQ + 2'd1;
          if (qQ == 2'd2 && bitQ == 4'd8) stb.sampleAck = 1'b1;
          if (qQ == 2'd3) begin
            if (bitQ != 4'd8) begin
              bitD      = bitQ + 4'd1;
              stb.shift = (bitQ < 4'd7);
            end else if (lastNack) begin
              stateD = ST_STOP; stb.flush = 1'b1; msmsClr = 1'b1;
            end else if (!msmsQ && fifoEmpty) begin
              stateD = ST_STOP;
            end else begin
              stateD = ST_HOLD;
            end
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  // Line levels per phase; SCL falls at the end of each bit so SDA moves with SCL low.
  always_comb begin
    sclLow = 1'b0; sdaLow = 1'b0;
    case (stateQ)
      ST_START:  begin sclLow = (qQ == 2'd3); sdaLow = qQ[1]; end
      ST_RSTART: begin sclLow = (qQ == 2'd0) || (qQ == 2'd3); sdaLow = qQ[1]; end
      ST_STOP:   begin sclLow = (qQ == 2'd0); sdaLow = !qQ[1]; end
      ST_HOLD:   begin sclLow = 1'b1; sdaLow = 1'b1; end
      ST_BIT:    begin
        sclLow = (qQ == 2'd0) || (qQ == 2'd3);
        sdaLow = (bitQ != 4'd8) && !txBit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE; qQ <= '0; bitQ <= '0; sclOe <= 1'b0; sdaOe <= 1'b0;
      enQ <= 1'b0; msmsQ <= 1'b0; txQ <= 1'b0; rstaQ <= 1'b0;
    end else begin
      stateQ <= stateD; qQ <= qD; bitQ <= bitD;
      sclOe  <= sclLow; sdaOe <= sdaLow;
      if (ctrlWe) begin
        enQ   <= ctrlWdata[CB_EN];   msmsQ <= ctrlWdata[CB_MSMS];
        txQ   <= ctrlWdata[CB_TX];   rstaQ <= ctrlWdata[CB_RSTA];
      end else begin
        if (msmsClr) msmsQ <= 1'b0;
        if (rstaClr) rstaQ <= 1'b0;
      end
    end
  end

  assert_sda_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BIT && $past(stateQ) == ST_BIT && !sclOe && !$past(sclOe))
      |-> sdaOe == $past(sdaOe));

  assert_hold_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && $past(stateQ) == ST_HOLD) |-> sclOe && sdaOe);

  assert_rsta_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rstaQ) && !$past(ctrlWe)) |-> $past(stateQ) == ST_RSTART);

  assert_nack_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !ctrlWe && tick && stateQ == ST_BIT && bitQ == 4'd8 && qQ == 2'd3 && lastNack)
      |=> stateQ == ST_STOP && !msmsQ);

  assert_start_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_START && $past(stateQ) == ST_IDLE) |-> $past(enQ && msmsQ && txQ));
endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
  import i2c_tx_pkg::*;
#(
  parameter int FIFO_DEPTH     = 16,
  parameter int QUARTER_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              fifoWe,
  input  logic [7:0]        fifoWdata,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [STAT_W-1:0] status,
  output logic              txEmptyIrq,
  output logic              ackValid,
  output logic              ackNack
);
  dpStrobe_t stb;
  logic tick, fifoEmpty, fifoFull, txBit, lastNack, nackFlag, overflow;
  logic busy, rstaPending;

  i2c_tx_ctrl ctrl_i (
    .clk, .rstN, .ctrlWe, .ctrlWdata, .tick, .fifoEmpty, .txBit, .lastNack,
    .stb, .sclOe, .sdaOe, .busy, .rstaPending, .txEmptyIrq
  );

  i2c_tx_dpath #(.FIFO_DEPTH(FIFO_DEPTH), .QUARTER_CYCLES(QUARTER_CYCLES)) dpath_i (
    .clk, .rstN, .stb, .fifoWe, .fifoWdata, .sdaIn, .tick, .fifoEmpty, .fifoFull,
    .txBit, .lastNack, .nackFlag, .overflow, .ackValid, .ackNack
  );

  assign status = {rstaPending, overflow, nackFlag, fifoFull, fifoEmpty, busy};
endmodule

// File: tb/i2c_tx_master_tb.sv
module i2c_tx_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QUARTER    = 2;
  localparam int DEPTH      = 16;
  localparam int BITCLK     = 4 * QUARTER;
  localparam logic [4:0] C_EN = 5'h01, C_FL = 5'h02, C_MS = 5'h04, C_TX = 5'h08, C_RS = 5'h10;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctrlWe = 1'b0, fifoWe = 1'b0;
  logic [4:0] ctrlWdata = '0;
  logic [7:0] fifoWdata = '0;
  logic sdaIn, sclOe, sdaOe, txEmptyIrq, ackValid, ackNack;
  logic [5:0] status;
  logic slaveDrive = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tx_master #(.FIFO_DEPTH(DEPTH), .QUARTER_CYCLES(QUARTER)) dut_i (
    .clk, .rstN, .ctrlWe, .ctrlWdata, .fifoWe, .fifoWdata, .sdaIn,
    .sclOe, .sdaOe, .status, .txEmptyIrq, .ackValid, .ackNack
  );
  assign sdaIn = !(sdaOe || slaveDrive);

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // Bus monitor and target model. Events: 0 START, 1 repeated START, 2 STOP, 3 byte.
  int evType [1024], evByte [1024], evAck [1024];
  int evCount = 0, bitCnt = 0, byteInFrame = 0, nackIndex = -1;
  int cyc = 0, lastRise = 0, periodErr = 0, ackPulses = 0, lastAckNack = 0;
  bit sclP = 1, sdaP = 1, inFrame = 0;
  logic [8:0] sh = '0;

  always @(negedge clk) begin
    logic scl, sda;
    scl = !sclOe; sda = !(sdaOe || slaveDrive);
    cyc++;
    if (ackValid) begin ackPulses++; lastAckNack = int'(ackNack); end
    if (sclP && scl && sdaP && !sda) begin
      evType[evCount] = inFrame ? 1 : 0; evCount++;
      inFrame = 1; bitCnt = 0; byteInFrame = 0;
    end else if (sclP && scl && !sdaP && sda) begin
      evType[evCount] = 2; evCount++; inFrame = 0; bitCnt = 0;
    end
    if (!sclP && scl) begin
      if (bitCnt >= 1 && cyc - lastRise != BITCLK) periodErr++;
      lastRise = cyc; sh = {sh[7:0], sda}; bitCnt++;
      if (bitCnt == 9) begin
        evType[evCount] = 3; evByte[evCount] = int'(sh[8:1]); evAck[evCount] = int'(sh[0]);
        evCount++; byteInFrame++; bitCnt = 0;
      end
    end
    if (sclP && !scl) begin
      if (slaveDrive) slaveDrive = 1'b0;
      else if (bitCnt == 8 && byteInFrame != nackIndex) slaveDrive = 1'b1;
    end
    sclP = scl; sdaP = sda;
  end

  int expType [1024], expByte [1024], expAck [1024];
  int expN = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expEv(input int t, input int b, input int a);
    expType[expN] = t; expByte[expN] = b; expAck[expN] = a; expN++;
  endtask

  task automatic checkSeq(input int base, input string req);
    chk(evCount - base == expN, {req, " event count"}, evCount - base, expN);
    for (int i = 0; i < expN && base + i < evCount; i++) begin
      chk(evType[base+i] == expType[i], {req, " event type"}, evType[base+i], expType[i]);
      if (expType[i] == 3) begin
        chk(evByte[base+i] == expByte[i], {req, " byte value"}, evByte[base+i], expByte[i]);
        chk(evAck[base+i] == expAck[i], {req, " ack bit"}, evAck[base+i], expAck[i]);
      end
    end
    expN = 0;
  endtask

  task automatic wrCtrl(input logic [4:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic push(input int v);
    @(negedge clk);
    while (status[2]) @(negedge clk);
    fifoWe = 1'b1; fifoWdata = 8'(v);
    @(negedge clk); fifoWe = 1'b0;
  endtask

  task automatic pushRaw(input int v);
    @(negedge clk); fifoWe = 1'b1; fifoWdata = 8'(v);
    @(negedge clk); fifoWe = 1'b0;
  endtask

  task automatic waitIrq();
    @(negedge clk);
    while (!txEmptyIrq) @(negedge clk);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (status[0]) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    int base, snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(status == 6'b000010, "R1 status", int'(status), 2);
    chk(!sclOe && !sdaOe, "R1 lines released", int'({sclOe, sdaOe}), 0);
    chk(!txEmptyIrq, "R1 irq", int'(txEmptyIrq), 0);

    // R2/R4/R6/R11: preloaded address, parked bus, full data sweep, stop
    base = evCount;
    push(8'hA0); push(8'h55);
    wrCtrl(C_EN | C_MS | C_TX);
    expEv(0, 0, 0); expEv(3, 8'hA0, 0); expEv(3, 8'h55, 0);
    waitIrq();
    snap = evCount;
    repeat (100) @(negedge clk);
    chk(sclOe == 1'b1, "R4 SCL held low", int'(sclOe), 1);
    chk(txEmptyIrq == 1'b1, "R4 irq while parked", int'(txEmptyIrq), 1);
    chk(evCount == snap, "R4 no bus activity while parked", evCount - snap, 0);
    for (int v = 0; v < 256; v++) begin push(v); expEv(3, v, 0); end
    waitIrq();
    wrCtrl(C_EN | C_TX);
    push(8'hC3); expEv(3, 8'hC3, 0); expEv(2, 0, 0);
    waitIdle();
    chk(status[0] == 1'b0, "R6 idle after stop", int'(status[0]), 0);
    checkSeq(base, "R2/R6 sweep");
    chk(periodErr == 0, "R11 SCL period", periodErr, 0);

    // R5: repeated start while parked
    base = evCount;
    push(8'h42); push(8'h81);
    wrCtrl(C_EN | C_MS | C_TX);
    waitIrq();
    wrCtrl(C_EN | C_MS | C_TX | C_RS);
    chk(status[5] == 1'b1, "R5 restart pending", int'(status[5]), 1);
    push(8'h43); push(8'h99);
    waitIrq();
    chk(status[5] == 1'b0, "R5 restart self-clears", int'(status[5]), 0);
    wrCtrl(C_EN | C_TX);
    push(8'h7E);
    waitIdle();
    expEv(0, 0, 0); expEv(3, 8'h42, 0); expEv(3, 8'h81, 0); expEv(1, 0, 0);
    expEv(3, 8'h43, 0); expEv(3, 8'h99, 0); expEv(3, 8'h7E, 0); expEv(2, 0, 0);
    checkSeq(base, "R5 restart");

    // R7: target NACKs the third byte of the frame
    base = evCount; snap = ackPulses;
    nackIndex = 2;
    push(8'h5A); push(8'h11); push(8'h22); push(8'h33);
    wrCtrl(C_EN | C_MS | C_TX);
    @(negedge clk); while (!status[0]) @(negedge clk);
    waitIdle();
    repeat (200) @(negedge clk);
    expEv(0, 0, 0); expEv(3, 8'h5A, 0); expEv(3, 8'h11, 0); expEv(3, 8'h22, 1); expEv(2, 0, 0);
    checkSeq(base, "R7 nack");
    chk(ackPulses - snap == 3, "R7 ack pulses", ackPulses - snap, 3);
    chk(lastAckNack == 1, "R7 last ackNack", lastAckNack, 1);
    chk(status[3] == 1'b1, "R7 nack status", int'(status[3]), 1);
    chk(status[1] == 1'b1, "R7 queue emptied", int'(status[1]), 1);
    chk(status[0] == 1'b0 && sclOe == 1'b0, "R7 no restart", int'(status[0]), 0);
    nackIndex = -1;

    // R8/R9: fill with the transfer disabled, overflow, flush
    wrCtrl(C_FL);
    for (int i = 0; i < DEPTH; i++) pushRaw(i * 7);
    @(negedge clk);
    chk(status[2] == 1'b1, "R8 full at depth", int'(status[2]), 1);
    chk(status[4] == 1'b0, "R8 no overflow yet", int'(status[4]), 0);
    pushRaw(8'hEE);
    @(negedge clk);
    chk(status[4] == 1'b1, "R8 overflow flagged", int'(status[4]), 1);
    chk(status[2] == 1'b1, "R8 still full", int'(status[2]), 1);
    wrCtrl(C_FL);
    @(negedge clk);
    chk(status[1] && !status[2] && !status[4], "R9 flush", int'(status), 2);

    // R10: master without transmit, or without enable, starts nothing
    base = evCount;
    push(8'h01); push(8'h02);
    wrCtrl(C_EN | C_MS);
    repeat (100) @(negedge clk);
    chk(!status[0] && !sclOe, "R10 no tx bit", int'(status[0]), 0);
    wrCtrl(C_MS | C_TX);
    repeat (100) @(negedge clk);
    chk(!status[0] && !sclOe, "R10 no enable", int'(status[0]), 0);
    chk(evCount == base, "R10 bus quiet", evCount - base, 0);
    wrCtrl(C_EN | C_MS | C_TX);
    waitIrq();
    chk(status[3] == 1'b0, "R7 nack cleared by start", int'(status[3]), 0);
    wrCtrl(C_EN | C_TX);
    push(8'h03);
    waitIdle();
    expEv(0, 0, 0); expEv(3, 8'h01, 0); expEv(3, 8'h02, 0); expEv(3, 8'h03, 0); expEv(2, 0, 0);
    checkSeq(base, "R10/R2 retry");
    chk(periodErr == 0, "R11 SCL period overall", periodErr, 0);

    summary();
  end
endmodule